// File: doc/BRIEF.md
# Taken-Branch Micro Target Buffer

This block is a small first-level branch target cache that sits beside instruction fetch. Each cycle fetch presents an address. In the same cycle the block returns a hit flag and a predicted next fetch address, so a taken branch can be followed without waiting for the slower main predictor. Only branches that resolved as taken are ever written into it.

A few cycles after each micro prediction, the main predictor reports its own verdict for the same fetch address, together with what the micro buffer had predicted. When the two disagree, the main predictor's outcome wins. The block raises a redirect in that same cycle, carrying either the main predictor's target or the sequential fall-through address. It also repairs its own storage: a hit overruled as not-taken is invalidated, and a hit overruled with another target has its target rewritten. Branch resolution drives a separate allocate/update port. A synchronous flush empties the buffer.

Top module: `fast_taken_btb`

## Requirements
- R1: While `lk_valid_i` is high, `lk_hit_o` is 1 in the same cycle exactly when a valid entry's tag equals `lk_addr_i`, and `lk_target_o` then carries that entry's target; on a miss `lk_target_o` is 0.
- R2: A resolution with `upd_taken_i` = 0 never creates, changes or removes an entry.
- R3: A taken resolution for an address already held rewrites that entry's target in place; an address is never held in two entries.
- R4: A taken resolution for a new address, while any entry is invalid, fills the lowest-numbered invalid entry.
- R5: When all ENTRIES (default 64) entries are valid, a new address replaces the entry under a round-robin pointer. The pointer is 0 after reset or flush, and each such replacement advances it by one, wrapping after ENTRIES-1.
- R6: When `chk_valid_i` is high and the main predictor disagrees with the micro prediction (hit versus taken differ, or both taken with different targets), `redirect_o` is 1 in that cycle. `redirect_addr_o` is then `chk_target_i` if `chk_taken_i` is 1, else `chk_fallthru_i`. Otherwise `redirect_o` is 0.
- R7: A disagreement where the micro prediction was a hit and the main predictor says not-taken invalidates the entry holding `chk_addr_i`.
- R8: A disagreement where both say taken with different targets rewrites the target of the entry holding `chk_addr_i` to `chk_target_i`.
- R9: `flush_i` invalidates every entry in one cycle and resets the round-robin pointer; an update or correction in the same cycle is dropped.
- R10: A lookup in the same cycle as an update of the same address returns the contents held before that update.
- R11: If a taken resolution and a correction act on the same entry in the same cycle, the resolution's address and target are kept and the entry stays valid.
- R12: After reset every lookup misses and `redirect_o` is 0 while no check is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous clear of all entries |
| lk_valid_i | input | 1 | Fetch lookup request |
| lk_addr_i | input | AW | Fetch address |
| lk_hit_o | output | 1 | Same-cycle taken prediction |
| lk_target_o | output | AW | Predicted next fetch address |
| upd_valid_i | input | 1 | Branch resolution present |
| upd_addr_i | input | AW | Resolved branch fetch address |
| upd_taken_i | input | 1 | Resolution outcome taken |
| upd_target_i | input | AW | Resolved target |
| chk_valid_i | input | 1 | Main predictor verdict present |
| chk_addr_i | input | AW | Fetch address being checked |
| chk_pred_hit_i | input | 1 | Micro buffer hit at that fetch |
| chk_pred_target_i | input | AW | Micro buffer target at that fetch |
| chk_taken_i | input | 1 | Main predictor says taken |
| chk_target_i | input | AW | Main predictor target |
| chk_fallthru_i | input | AW | Sequential fetch address after the checked one |
| redirect_o | output | 1 | Main predictor overrules, redirect fetch |
| redirect_addr_o | output | AW | Address to redirect to |

## Verification
A resolution and a main-predictor correction can land on the same entry in the same cycle, and a fetch lookup can read an address that is being written in that cycle. The bench provokes both on purpose: it kills an entry while resolving that same address as taken with a new target, and it looks up an address in the cycle it is allocated. A long random phase over an address pool larger than the buffer makes these collisions and forced replacements frequent. A behavioural model applies the correction first and the resolution second, and it serves lookups from pre-edge state. Each cycle the hit, target and redirect outputs are compared against it.

// File: rtl/fast_taken_btb.sv
module fast_taken_btb #(
  parameter int ENTRIES = 64,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          lk_valid_i,
  input  logic [AW-1:0] lk_addr_i,
  output logic          lk_hit_o,
  output logic [AW-1:0] lk_target_o,
  input  logic          upd_valid_i,
  input  logic [AW-1:0] upd_addr_i,
  input  logic          upd_taken_i,
  input  logic [AW-1:0] upd_target_i,
  input  logic          chk_valid_i,
  input  logic [AW-1:0] chk_addr_i,
  input  logic          chk_pred_hit_i,
  input  logic [AW-1:0] chk_pred_target_i,
  input  logic          chk_taken_i,
  input  logic [AW-1:0] chk_target_i,
  input  logic [AW-1:0] chk_fallthru_i,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_addr_o
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [AW-1:0]      tag_q [ENTRIES];
  logic [AW-1:0]      tgt_q [ENTRIES];
  logic [IW-1:0]      rr_q;

  logic [ENTRIES-1:0] lk_match, upd_match, chk_match;
  logic [IW-1:0]      free_idx, hit_idx, upd_idx;
  logic               free_any, upd_hit, upd_we, replace;
  logic               disagree, fix_en, fix_kill, fix_tgt;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g]  = lk_valid_i && valid_q[g] && (tag_q[g] == lk_addr_i);
    assign upd_match[g] = valid_q[g] && (tag_q[g] == upd_addr_i);
    assign chk_match[g] = valid_q[g] && (tag_q[g] == chk_addr_i);
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) free_idx = IW'(i);
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (upd_match[i]) hit_idx = IW'(i);
    lk_target_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) lk_target_o = lk_target_o | tgt_q[i];
  end

  assign lk_hit_o = |lk_match;

  assign free_any = ~&valid_q;
  assign upd_hit  = |upd_match;
  assign upd_we   = upd_valid_i && upd_taken_i && !flush_i;
  assign upd_idx  = upd_hit ? hit_idx : (free_any ? free_idx : rr_q);
  assign replace  = upd_we && !upd_hit && !free_any;

  assign disagree = (chk_pred_hit_i != chk_taken_i) ||
                    (chk_taken_i && chk_pred_target_i != chk_target_i);
  assign redirect_o      = chk_valid_i && disagree;
  assign redirect_addr_o = chk_taken_i ? chk_target_i : chk_fallthru_i;
  assign fix_en   = redirect_o && chk_pred_hit_i && !flush_i;
  assign fix_kill = fix_en && !chk_taken_i;
  assign fix_tgt  = fix_en && chk_taken_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (upd_we && upd_idx == IW'(i)) valid_q[i] <= 1'b1;
        else if (fix_kill && chk_match[i]) valid_q[i] <= 1'b0;
      end
      if (replace) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (upd_we && upd_idx == IW'(i)) begin
        tag_q[i] <= upd_addr_i;
        tgt_q[i] <= upd_target_i;
      end else if (fix_tgt && chk_match[i]) begin
        tgt_q[i] <= chk_target_i;
      end
    end
  end

  a_r3_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_match));
  a_r1_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit_o |-> lk_target_o == '0);
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_q == '0 && rr_q == '0));
  a_r2_not_taken_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_i && !upd_taken_i && !chk_valid_i && !flush_i) |=> $stable(valid_q));
  a_r5_pointer_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rr_q) |-> ($past(flush_i) || $past(&valid_q)));
  a_r6_not_taken_overrule: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && chk_pred_hit_i && !chk_taken_i) |->
      (redirect_o && redirect_addr_o == chk_fallthru_i));
endmodule

// File: tb/test_fast_taken_btb.sv
`timescale 1ns/100ps
module test_fast_taken_btb;
  localparam int ENT = 64;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0, flush_i = 1'b0;
  logic lk_valid_i = 1'b0, upd_valid_i = 1'b0, upd_taken_i = 1'b0;
  logic chk_valid_i = 1'b0, chk_pred_hit_i = 1'b0, chk_taken_i = 1'b0;
  logic [AW-1:0] lk_addr_i = '0, upd_addr_i = '0, upd_target_i = '0;
  logic [AW-1:0] chk_addr_i = '0, chk_pred_target_i = '0, chk_target_i = '0, chk_fallthru_i = '0;
  logic lk_hit_o, redirect_o;
  logic [AW-1:0] lk_target_o, redirect_addr_o;

  int nchecks = 0, nerr = 0;
  bit done = 0;

  bit            mv   [ENT];
  logic [AW-1:0] mtag [ENT];
  logic [AW-1:0] mtgt [ENT];
  int            mptr = 0;

  fast_taken_btb #(.ENTRIES(ENT), .AW(AW)) i_fast_taken_btb (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i), .lk_hit_o(lk_hit_o), .lk_target_o(lk_target_o),
    .upd_valid_i(upd_valid_i), .upd_addr_i(upd_addr_i), .upd_taken_i(upd_taken_i), .upd_target_i(upd_target_i),
    .chk_valid_i(chk_valid_i), .chk_addr_i(chk_addr_i), .chk_pred_hit_i(chk_pred_hit_i),
    .chk_pred_target_i(chk_pred_target_i), .chk_taken_i(chk_taken_i), .chk_target_i(chk_target_i),
    .chk_fallthru_i(chk_fallthru_i), .redirect_o(redirect_o), .redirect_addr_o(redirect_addr_o));

  always #2.5 clk = ~clk;

  function automatic logic [AW-1:0] pa(int i);
    return 32'h0001_0000 + AW'(i) * 4;
  endfunction

  function automatic int mfind(logic [AW-1:0] a);
    for (int i = 0; i < ENT; i++) if (mv[i] && mtag[i] == a) return i;
    return -1;
  endfunction

  task automatic cmp(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    flush_i = 0; lk_valid_i = 0; upd_valid_i = 0; upd_taken_i = 0;
    chk_valid_i = 0; chk_pred_hit_i = 0; chk_taken_i = 0;
  endtask

  task automatic step(string req);
    int k, c, u;
    bit exp_red;
    #1;
    k = lk_valid_i ? mfind(lk_addr_i) : -1;
    cmp(req, "lk_hit", AW'(lk_hit_o), AW'(k >= 0));
    cmp(req, "lk_target", lk_target_o, (k >= 0) ? mtgt[k] : '0);
    exp_red = chk_valid_i && ((chk_pred_hit_i != chk_taken_i) ||
              (chk_taken_i && chk_pred_target_i != chk_target_i));
    cmp("R6", "redirect", AW'(redirect_o), AW'(exp_red));
    if (exp_red) cmp("R6", "redirect_addr", redirect_addr_o, chk_taken_i ? chk_target_i : chk_fallthru_i);
    @(posedge clk);
    if (flush_i) begin
      for (int i = 0; i < ENT; i++) mv[i] = 0;
      mptr = 0;
    end else begin
      c = (exp_red && chk_pred_hit_i) ? mfind(chk_addr_i) : -1;
      u = -1;
      if (upd_valid_i && upd_taken_i) begin
        u = mfind(upd_addr_i);
        if (u < 0) for (int i = ENT - 1; i >= 0; i--) if (!mv[i]) u = i;
        if (u < 0) begin u = mptr; mptr = (mptr + 1) % ENT; end
      end
      if (c >= 0) begin
        if (!chk_taken_i) mv[c] = 0; else mtgt[c] = chk_target_i;
      end
      if (u >= 0) begin mv[u] = 1; mtag[u] = upd_addr_i; mtgt[u] = upd_target_i; end
    end
    @(negedge clk);
    idle();
  endtask

  task automatic look(string req, logic [AW-1:0] a);
    lk_valid_i = 1; lk_addr_i = a; step(req);
  endtask

  task automatic resolve(logic [AW-1:0] a, bit tk, logic [AW-1:0] t);
    upd_valid_i = 1; upd_addr_i = a; upd_taken_i = tk; upd_target_i = t;
  endtask

  task automatic verdict(logic [AW-1:0] a, bit ph, logic [AW-1:0] pt, bit tk, logic [AW-1:0] t);
    chk_valid_i = 1; chk_addr_i = a; chk_pred_hit_i = ph; chk_pred_target_i = pt;
    chk_taken_i = tk; chk_target_i = t; chk_fallthru_i = a + 4;
  endtask

  initial begin
    for (int i = 0; i < ENT; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    look("R12", pa(0)); look("R12", pa(7));
    resolve(pa(0), 0, 32'h900); step("R2");
    look("R2", pa(0));
    resolve(pa(0), 1, 32'h900); step("R1");
    look("R1", pa(0));
    resolve(pa(1), 1, 32'h910); lk_valid_i = 1; lk_addr_i = pa(1); step("R10");
    look("R10", pa(1));
    resolve(pa(0), 1, 32'hA00); step("R3");
    look("R3", pa(0));
    for (int i = 2; i < ENT; i++) begin resolve(pa(i), 1, 32'h5000 + i); step("R4"); end
    for (int i = 0; i < ENT; i++) look("R4", pa(i));
    resolve(pa(64), 1, 32'h7000); step("R5");
    look("R5", pa(0)); look("R5", pa(64));
    resolve(pa(65), 1, 32'h7004); step("R5");
    look("R5", pa(1)); look("R5", pa(2));
    verdict(pa(2), 1, 32'h5002, 0, 0); step("R6");
    look("R7", pa(2));
    verdict(pa(3), 1, 32'h5003, 1, 32'h6666); step("R6");
    look("R8", pa(3));
    verdict(pa(5), 1, 32'h5005, 1, 32'h5005); step("R6");
    verdict(pa(70), 0, 0, 1, 32'h8888); step("R6");
    look("R6", pa(70));
    verdict(pa(4), 1, 32'h5004, 0, 0); resolve(pa(4), 1, 32'h4444); step("R11");
    look("R11", pa(4));
    flush_i = 1; resolve(pa(71), 1, 32'h1234); verdict(pa(5), 1, 32'h5005, 1, 32'h9); step("R9");
    look("R9", pa(71)); look("R9", pa(5)); look("R9", pa(64));
    for (int n = 0; n < 4000; n++) begin
      int k;
      lk_valid_i = ($urandom % 4) != 0; lk_addr_i = pa($urandom % 80);
      if ($urandom % 2) resolve(pa($urandom % 80), ($urandom % 10) < 7, 32'h100 + ($urandom % 4));
      if (($urandom % 10) < 3) begin
        chk_addr_i = pa($urandom % 80);
        k = mfind(chk_addr_i);
        verdict(chk_addr_i, k >= 0, (k >= 0) ? mtgt[k] : '0, $urandom % 2, 32'h100 + ($urandom % 4));
      end
      flush_i = ($urandom % 100) == 0;
      step("R1");
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      nchecks++; nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end
endmodule